// File: doc/BRIEF.md
# Saturating Two-Digit Ticket Counter

This block keeps a queue number of the kind shown above a service desk. Each clean press of a push button advances a two-digit decimal count that starts at 00. The count stops at 80 and holds there. A clear switch returns the count to 00 from any value.

The ones and tens digits are held as separate BCD registers and change together in a single clock edge, so there is no carry ripple between them. A refresh timer alternates between the two digits on one shared segment bus. The displays are common-cathode: a segment line is driven high to light it, and a digit is selected by driving its common line low. The raw button passes through a two-flop synchroniser and a stability filter before it can advance the count. The clear switch passes through its own two-flop synchroniser.

Top module: `ticket_counter`

## Requirements
- R1: While rst_ni is low, and right after it is released, the display shows 00, the decimal point is off, and the ones digit is the one selected.
- R2: Each accepted button press adds exactly one to the ones digit, whatever its current value from 0 to 8.
- R3: When an accepted press finds the ones digit at 9 and the tens digit below 8, the ones digit goes to 0 and the tens digit rises by one at the same clock edge.
- R4: Once the count is 80, accepted presses change nothing and the count stays at 80.
- R5: clr_i passes through two synchroniser flops. While the synchronised clear is high, both digits are forced to 0 from any value, 80 included.
- R6: A press accepted in the same cycle as the synchronised clear is dropped. Presses made while clear is held high are not counted afterwards.
- R7: After two synchroniser flops, btn_i must hold a new level for DEB_CYCLES consecutive clocks before that level is accepted. Shorter pulses and glitches are ignored. Each accepted rising level gives exactly one increment, however long the button is held.
- R8: dig_en_o is active low, with bit 0 for the ones digit and bit 1 for the tens digit. Exactly one bit is low at any time. The selection starts on the ones digit and toggles every REFRESH_CYCLES clocks.
- R9: seg_o is active high, with bit 0 = a through bit 6 = g. It carries the pattern of the selected digit in the same cycle as dig_en_o. The hex patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. The tens digit is always shown, including a leading 0.
- R10: dp_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Raw, bouncing push button, active high |
| clr_i | input | 1 | Clear switch, active high |
| seg_o | output | 7 | Segment lines a..g, active high |
| dp_o | output | 1 | Decimal point, held off |
| dig_en_o | output | 2 | Digit common lines, active low (bit 0 ones, bit 1 tens) |

## Verification
The bench goes after these corner cases:
- **Carry from 9 to 10 and from 79 to 80.** A design that rippled the carry, or that updated the tens digit one edge late, would show x0 with the wrong tens digit for a cycle.
- **Presses past 80.** A design that wrapped at 99, or that kept counting internally past 80, would leave 80.
- **Short bounces and a glitch in the middle of a long hold.** A filter that reacted to a single sampled level would count extra presses.
- **Clear held during presses, and clear from the saturated value.** A design that gave the increment priority over clear would leave a non-zero count.

The segment and enable lines are also compared each cycle against a behavioural model. This catches a digit pattern presented one cycle out of step with its enable.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef logic [3:0] bcd_t;

  // active-high segments, bit0 = a .. bit6 = g
  function automatic logic [6:0] seg_of(bcd_t d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tc_debounce.sv
module tc_debounce #(
  parameter int unsigned STABLE_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYCLES - 1);

  logic s1_q, s2_q, lvl_q, lvl_d1_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      lvl_q    <= 1'b0;
      lvl_d1_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      s1_q     <= raw_i;
      s2_q     <= s1_q;
      lvl_d1_q <= lvl_q;
      if (s2_q != lvl_q) begin
        if (cnt_q == LIM) begin
          lvl_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0; // any return to the old level restarts the window
      end
    end
  end

  assign rise_o = lvl_q & ~lvl_d1_q;

  // R7: one increment per accepted press
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r7_level_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == LIM));
endmodule

// File: rtl/tc_bcd_count.sv
module tc_bcd_count
  import tc_pkg::*;
#(
  parameter int unsigned MAX_TENS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t ones_o,
  output bcd_t tens_o
);
  localparam bcd_t TENS_TOP = bcd_t'(MAX_TENS);

  logic at_top;
  assign at_top = (tens_o == TENS_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_o <= '0;
      tens_o <= '0;
    end else if (clr_i) begin
      ones_o <= '0;
      tens_o <= '0;
    end else if (inc_i && !at_top) begin
      if (ones_o == 4'd9) begin
        ones_o <= '0;
        tens_o <= tens_o + 4'd1;
      end else begin
        ones_o <= ones_o + 4'd1;
      end
    end
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_top && ones_o != 4'd9)
      |=> (ones_o == $past(ones_o) + 4'd1) && $stable(tens_o));
  a_r3_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_top && ones_o == 4'd9)
      |=> (ones_o == 4'd0) && (tens_o == $past(tens_o) + 4'd1));
  a_r4_hold_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_top && !clr_i) |=> $stable(ones_o) && $stable(tens_o));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ones_o == 4'd0) && (tens_o == 4'd0));
  a_r2_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_o <= 4'd9) && (tens_o <= TENS_TOP));
endmodule

// File: rtl/tc_disp_mux.sv
module tc_disp_mux
  import tc_pkg::*;
#(
  parameter int unsigned REFRESH_CYCLES = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bcd_t       ones_i,
  input  bcd_t       tens_i,
  output logic [6:0] seg_o,
  output logic [1:0] dig_en_o
);
  localparam int unsigned RW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [RW-1:0] RLIM = RW'(REFRESH_CYCLES - 1);

  logic [RW-1:0] rc_q;
  logic          sel_q; // 0 = ones, 1 = tens

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q  <= '0;
      sel_q <= 1'b0;
    end else if (rc_q == RLIM) begin
      rc_q  <= '0;
      sel_q <= ~sel_q;
    end else begin
      rc_q <= rc_q + 1'b1;
    end
  end

  // pattern and enable come from the same select to avoid ghosting
  assign seg_o    = seg_of(sel_q ? tens_i : ones_i);
  assign dig_en_o = sel_q ? 2'b01 : 2'b10;

  a_r8_one_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dig_en_o) == 1);
  a_r8_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_q != RLIM) |=> $stable(dig_en_o));
  a_r8_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_q == RLIM) |=> (dig_en_o != $past(dig_en_o)));
endmodule

// File: rtl/ticket_counter.sv
module ticket_counter
  import tc_pkg::*;
#(
  parameter int unsigned DEB_CYCLES     = 500000,
  parameter int unsigned REFRESH_CYCLES = 50000,
  parameter int unsigned MAX_TENS       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_i,
  input  logic       clr_i,
  output logic [6:0] seg_o,
  output logic       dp_o,
  output logic [1:0] dig_en_o
);
  logic clr_s1_q, clr_s2_q;
  logic inc_pulse;
  bcd_t ones, tens;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_s1_q <= 1'b0;
      clr_s2_q <= 1'b0;
    end else begin
      clr_s1_q <= clr_i;
      clr_s2_q <= clr_s1_q;
    end
  end

  tc_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (btn_i),
    .rise_o(inc_pulse)
  );

  tc_bcd_count #(.MAX_TENS(MAX_TENS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_s2_q),
    .inc_i (inc_pulse),
    .ones_o(ones),
    .tens_o(tens)
  );

  tc_disp_mux #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ones_i  (ones),
    .tens_i  (tens),
    .seg_o   (seg_o),
    .dig_en_o(dig_en_o)
  );

  assign dp_o = 1'b0;

  // R6: clear wins over a coincident press
  a_r6_clear_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s2_q && inc_pulse) |=> (ones == 4'd0) && (tens == 4'd0));
endmodule

// File: tb/ticket_counter_tb.sv
module ticket_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 6;
  localparam int REF = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic btn = 1'b0;
  logic clr = 1'b0;
  logic [6:0] seg;
  logic dp;
  logic [1:0] dig_en;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ticket_counter #(.DEB_CYCLES(DEB), .REFRESH_CYCLES(REF), .MAX_TENS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_i(btn), .clr_i(clr),
    .seg_o(seg), .dp_o(dp), .dig_en_o(dig_en)
  );

  function automatic logic [6:0] exp_seg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic int seg2dig(logic [6:0] s);
    for (int d = 0; d < 10; d++) if (exp_seg(d) == s) return d;
    return -1;
  endfunction

  // behavioural reference model
  int m_val, m_s1, m_s2, m_db, m_dbd, m_cnt, m_c1, m_c2, m_rc, m_sel;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_val = 0; m_s1 = 0; m_s2 = 0; m_db = 0; m_dbd = 0; m_cnt = 0;
      m_c1 = 0; m_c2 = 0; m_rc = 0; m_sel = 0;
    end else begin
      if (m_c2 != 0) m_val = 0;
      else if (m_db != 0 && m_dbd == 0 && m_val < 80) m_val = m_val + 1;
      m_dbd = m_db;
      if (m_s2 != m_db) begin
        if (m_cnt == DEB - 1) begin m_db = m_s2; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end else m_cnt = 0;
      m_s2 = m_s1; m_s1 = int'(btn);
      m_c2 = m_c1; m_c1 = int'(clr);
      if (m_rc == REF - 1) begin m_rc = 0; m_sel = 1 - m_sel; end
      else m_rc = m_rc + 1;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      check("R8", "dig_en", int'(dig_en), (m_sel != 0) ? 1 : 2);
      check(cur_tag, "seg", int'(seg),
            int'(exp_seg((m_sel != 0) ? (m_val / 10) : (m_val % 10))));
      check("R10", "dp", int'(dp), 0);
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    @(negedge clk) btn = 1'b1;
    wait_cycles(DEB + 6);
    btn = 1'b0;
    wait_cycles(DEB + 6);
  endtask

  // reads both digits at the ports
  task automatic read_display(output int v);
    int o, t;
    o = -1; t = -1;
    while (o < 0 || t < 0) begin
      @(negedge clk);
      if (dig_en == 2'b10) o = seg2dig(seg);
      else if (dig_en == 2'b01) t = seg2dig(seg);
    end
    v = t * 10 + o;
  endtask

  initial begin
    int v;
    #(CLK_PERIOD * 3);
    check("R1", "seg in reset", int'(seg), int'(exp_seg(0)));
    check("R1", "dig_en in reset", int'(dig_en), 2);
    check("R1", "dp in reset", int'(dp), 0);
    @(negedge clk) rst_ni = 1'b1;
    read_display(v); check("R1", "value after reset", v, 0);

    cur_tag = "R2";
    for (int i = 0; i < 5; i++) press();
    read_display(v); check("R2", "five presses", v, 5);

    cur_tag = "R7";
    @(negedge clk) btn = 1'b1; wait_cycles(DEB - 1); btn = 1'b0; wait_cycles(DEB + 6);
    @(negedge clk) btn = 1'b1; wait_cycles(2); btn = 1'b0; wait_cycles(DEB + 6);
    read_display(v); check("R7", "short bounces ignored", v, 5);
    @(negedge clk) btn = 1'b1; wait_cycles(DEB + 6);
    btn = 1'b0; wait_cycles(2); btn = 1'b1; wait_cycles(4 * DEB);
    btn = 1'b0; wait_cycles(DEB + 6);
    read_display(v); check("R7", "long hold with glitch counts once", v, 6);

    cur_tag = "R3";
    for (int i = 0; i < 4; i++) press();
    read_display(v); check("R3", "carry 9 to 10", v, 10);

    cur_tag = "R4";
    for (int i = 0; i < 70; i++) press();
    read_display(v); check("R3", "carry to 80", v, 80);
    for (int i = 0; i < 5; i++) press();
    read_display(v); check("R4", "held at 80", v, 80);

    cur_tag = "R5";
    @(negedge clk) clr = 1'b1; wait_cycles(4);
    read_display(v); check("R5", "clear from 80", v, 0);

    cur_tag = "R6";
    for (int i = 0; i < 3; i++) press();
    clr = 1'b0; wait_cycles(4);
    read_display(v); check("R6", "presses under clear dropped", v, 0);

    cur_tag = "R9";
    for (int i = 0; i < 23; i++) press();
    read_display(v); check("R9", "leading digit shown", v, 23);
    @(negedge clk) clr = 1'b1; wait_cycles(4); clr = 1'b0; wait_cycles(4);
    read_display(v); check("R5", "clear mid count", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule